// File: doc/BRIEF.md
# FIFO Mailbox Channel with Watermark

This block is a one-way message channel between two processors. The sending side writes 32-bit words into a push register; the words queue in a 32-entry first-in first-out store; the receiving side takes them out through a pop register. Both sides share one 32-bit register interface. Each access is one cycle wide: a write takes effect at the clock edge that samples it, and read data is returned combinationally in the same cycle as the read request.

A watermark register gives a level in words. The status register reports whether the occupancy is at or above that level, together with full, empty and two sticky error flags for underflow and overflow. A flush register empties the store.

Interrupt sources are captured as events into one status word. Each side has its own enable mask and drives its own interrupt line. The sender enables the empty event and treats it as "transmit complete". The receiver enables the upward watermark crossing or the full event, then pops words until the status register reports empty.

The fill level is tracked by a three-state machine with these states:
- FILL_EMPTY: no words held.
- FILL_PART: between one and DEPTH-1 words held.
- FILL_FULL: DEPTH words held.

Its transitions are:
- FILL_EMPTY to FILL_PART on a push.
- FILL_PART to FILL_PART on a push below DEPTH-1 words, or on a pop above one word.
- FILL_PART to FILL_FULL on a push at DEPTH-1 words.
- FILL_PART to FILL_EMPTY on a pop at one word.
- FILL_FULL to FILL_PART on a pop.
- Any state to FILL_EMPTY on a flush.

Top module: `mbx_fifo_chan`

## Requirements
- R1: After reset the registers read as follows: status (offset 0xB4) reads 0x4 (empty only), the watermark (0xB8) reads 32, interrupt status (0xDC) reads 0, both enables (0xD0 side A, 0xD4 side B) read 0, and both interrupt lines are low.
- R2: Words written to the push register (0xAC) are returned by reads of the pop register (0xB0) in the order they were written, and each read removes one word.
- R3: After 32 pushes, status bit 1 (full) is set. A further push is dropped and the dropped word is never returned. That push sets the sticky overflow flag, which appears as status bit 4 and interrupt status bit 6.
- R4: A pop while empty returns 0 and sets the sticky underflow flag, which appears as status bit 3 and interrupt status bit 7.
- R5: Status bit 0 is set exactly when the occupancy is at or above the watermark value. The watermark register is writable and reads back the written value.
- R6: When status bit 0 goes from 0 to 1, interrupt status bit 4 is set. When it goes from 1 to 0, interrupt status bit 5 is set.
- R7: Interrupt status bit 2 is set on entry into full, bit 3 on entry into empty, and bit 8 on leaving empty. Once cleared, these bits stay clear while the condition persists.
- R8: Writing the clear register (0xD8) clears exactly those interrupt status bits written as 1. Clearing bit 6 or bit 7 also clears the matching status error flag.
- R9: Each enable register implements bits 2 to 8 only, and its other bits read 0. irq_a is high while any interrupt status bit enabled in side A's mask is set, and irq_b likewise with side B's mask.
- R10: Writing 1 to bit 0 of the flush register (0xCC) empties the store and clears both error flags, leaving the watermark unchanged. Writing 0 there has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read request |
| irq_a | output | 1 | Sender-side interrupt |
| irq_b | output | 1 | Receiver-side interrupt |

## Verification
The bench builds the block with its default parameters: a 32-word depth and 32-bit words. With these values, filling to full, overflowing and draining complete within about seventy bus accesses, so the full-entry, overflow and both watermark crossings are each driven at their exact boundary word. Running the default 32-word watermark alongside a small programmed one exercises the crossing at the full boundary and again at an interior level. The bench predicts the event bits from the order of pushes and pops.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_e;

    localparam logic [7:0] OFS_PUSH  = 8'hAC;
    localparam logic [7:0] OFS_POP   = 8'hB0;
    localparam logic [7:0] OFS_STAT  = 8'hB4;
    localparam logic [7:0] OFS_WMARK = 8'hB8;
    localparam logic [7:0] OFS_FLUSH = 8'hCC;
    localparam logic [7:0] OFS_IEN_A = 8'hD0;
    localparam logic [7:0] OFS_IEN_B = 8'hD4;
    localparam logic [7:0] OFS_ICLR  = 8'hDC - 8'h04;
    localparam logic [7:0] OFS_ISTAT = 8'hDC;

    localparam int IRQ_W      = 9;
    localparam int EV_FULL    = 2;
    localparam int EV_EMPTY   = 3;
    localparam int EV_WM_UP   = 4;
    localparam int EV_WM_DN   = 5;
    localparam int EV_OFLOW   = 6;
    localparam int EV_UFLOW   = 7;
    localparam int EV_NEMPTY  = 8;
    localparam logic [IRQ_W-1:0] IRQ_IMPL = 9'h1FC;

    localparam int ST_WM    = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_EMPTY = 2;
    localparam int ST_UFLOW = 3;
    localparam int ST_OFLOW = 4;

endpackage

// File: rtl/mbx_fifo_store.sv
module mbx_fifo_store
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  count_d,
    output fill_state_e       state_q,
    output fill_state_e       state_d,
    output logic              ovf_ev,
    output logic              unf_ev
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // next-state and occupancy logic of the fill machine
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        if (flush) begin
            state_d = FILL_EMPTY;
            count_d = '0;
        end else begin
            unique case (state_q)
                FILL_EMPTY: begin
                    if (push) begin
                        push_ok = 1'b1;
                        count_d = count_q + CNT_ONE;
                        state_d = (count_q == CNT_LAST) ? FILL_FULL : FILL_PART;
                    end
                end
                FILL_PART: begin
                    if (push) begin
                        push_ok = 1'b1;
                        count_d = count_q + CNT_ONE;
                        if (count_q == CNT_LAST) state_d = FILL_FULL;
                    end else if (pop) begin
                        pop_ok  = 1'b1;
                        count_d = count_q - CNT_ONE;
                        if (count_q == CNT_ONE) state_d = FILL_EMPTY;
                    end
                end
                FILL_FULL: begin
                    if (pop) begin
                        pop_ok  = 1'b1;
                        count_d = count_q - CNT_ONE;
                        state_d = (count_q == CNT_ONE) ? FILL_EMPTY : FILL_PART;
                    end
                end
                default: begin
                    state_d = FILL_EMPTY;
                    count_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            count_q <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= ptr_next(wr_ptr);
                if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // outputs
    always_comb begin
        head_data = (state_q == FILL_EMPTY) ? '0 : mem[rd_ptr];
        ovf_ev    = push && !flush && (state_q == FILL_FULL);
        unf_ev    = pop  && !flush && (state_q == FILL_EMPTY);
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FILL_FULL && push && !flush) |=> $stable(count_q));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == FILL_EMPTY && count_q == '0));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fill_state_e      state_q,
    input  fill_state_e      state_d,
    input  logic             wm_hit_q,
    input  logic             wm_hit_d,
    input  logic             ovf_ev,
    input  logic             unf_ev,
    input  logic             flush,
    input  logic             clr_we,
    input  logic             ena_we,
    input  logic             enb_we,
    input  logic [IRQ_W-1:0] reg_wdata,
    output logic [IRQ_W-1:0] istat_q,
    output logic [IRQ_W-1:0] en_a_q,
    output logic [IRQ_W-1:0] en_b_q,
    output logic             irq_a,
    output logic             irq_b
);

    logic [IRQ_W-1:0] ev_set;
    logic [IRQ_W-1:0] istat_d;

    always_comb begin
        ev_set             = '0;
        ev_set[EV_FULL]    = (state_d == FILL_FULL)  && (state_q != FILL_FULL);
        ev_set[EV_EMPTY]   = (state_d == FILL_EMPTY) && (state_q != FILL_EMPTY);
        ev_set[EV_NEMPTY]  = (state_q == FILL_EMPTY) && (state_d != FILL_EMPTY);
        ev_set[EV_WM_UP]   = wm_hit_d && !wm_hit_q;
        ev_set[EV_WM_DN]   = !wm_hit_d && wm_hit_q;
        ev_set[EV_OFLOW]   = ovf_ev;
        ev_set[EV_UFLOW]   = unf_ev;

        istat_d = istat_q;
        if (clr_we) istat_d = istat_d & ~reg_wdata;
        if (flush) begin
            istat_d[EV_OFLOW] = 1'b0;
            istat_d[EV_UFLOW] = 1'b0;
        end
        istat_d = (istat_d | ev_set) & IRQ_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            istat_q <= '0;
            en_a_q  <= '0;
            en_b_q  <= '0;
        end else begin
            istat_q <= istat_d;
            if (ena_we) en_a_q <= reg_wdata & IRQ_IMPL;
            if (enb_we) en_b_q <= reg_wdata & IRQ_IMPL;
        end
    end

    always_comb begin
        irq_a = |(istat_q & en_a_q);
        irq_b = |(istat_q & en_b_q);
    end

    p_oflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (istat_q[EV_OFLOW] && !(clr_we && reg_wdata[EV_OFLOW]) && !flush)
        |=> istat_q[EV_OFLOW]);

    p_wm_rise_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wm_hit_q) |-> istat_q[EV_WM_UP]);

    p_full_entry_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == FILL_FULL) |-> istat_q[EV_FULL]);

endmodule

// File: rtl/mbx_fifo_chan.sv
module mbx_fifo_chan
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_a,
    output logic              irq_b
);

    logic              wr_acc, rd_acc;
    logic              push, pop, flush;
    logic              wm_we, ena_we, enb_we, clr_we;
    logic [CNT_W-1:0]  wm_q, wm_d;
    logic [CNT_W-1:0]  count_q, count_d;
    fill_state_e       state_q, state_d;
    logic              ovf_ev, unf_ev;
    logic              wm_hit_q, wm_hit_d;
    logic [DATA_W-1:0] head_data;
    logic [IRQ_W-1:0]  istat_q, en_a_q, en_b_q;
    logic [DATA_W-1:0] status_word;

    // register decode
    always_comb begin
        wr_acc = bus_valid && bus_write;
        rd_acc = bus_valid && !bus_write;
        push   = wr_acc && (bus_addr == ADDR_W'(OFS_PUSH));
        pop    = rd_acc && (bus_addr == ADDR_W'(OFS_POP));
        flush  = wr_acc && (bus_addr == ADDR_W'(OFS_FLUSH)) && bus_wdata[0];
        wm_we  = wr_acc && (bus_addr == ADDR_W'(OFS_WMARK));
        ena_we = wr_acc && (bus_addr == ADDR_W'(OFS_IEN_A));
        enb_we = wr_acc && (bus_addr == ADDR_W'(OFS_IEN_B));
        clr_we = wr_acc && (bus_addr == ADDR_W'(OFS_ICLR));
        wm_d   = wm_we ? bus_wdata[CNT_W-1:0] : wm_q;
        wm_hit_q = (count_q >= wm_q);
        wm_hit_d = (count_d >= wm_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wm_q <= CNT_W'(DEPTH);
        else        wm_q <= wm_d;
    end

    mbx_fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .flush     (flush),
        .push_data (bus_wdata),
        .head_data (head_data),
        .count_q   (count_q),
        .count_d   (count_d),
        .state_q   (state_q),
        .state_d   (state_d),
        .ovf_ev    (ovf_ev),
        .unf_ev    (unf_ev)
    );

    mbx_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .state_d   (state_d),
        .wm_hit_q  (wm_hit_q),
        .wm_hit_d  (wm_hit_d),
        .ovf_ev    (ovf_ev),
        .unf_ev    (unf_ev),
        .flush     (flush),
        .clr_we    (clr_we),
        .ena_we    (ena_we),
        .enb_we    (enb_we),
        .reg_wdata (bus_wdata[IRQ_W-1:0]),
        .istat_q   (istat_q),
        .en_a_q    (en_a_q),
        .en_b_q    (en_b_q),
        .irq_a     (irq_a),
        .irq_b     (irq_b)
    );

    // read path
    always_comb begin
        status_word           = '0;
        status_word[ST_WM]    = wm_hit_q;
        status_word[ST_FULL]  = (state_q == FILL_FULL);
        status_word[ST_EMPTY] = (state_q == FILL_EMPTY);
        status_word[ST_UFLOW] = istat_q[EV_UFLOW];
        status_word[ST_OFLOW] = istat_q[EV_OFLOW];

        bus_rdata = '0;
        if (rd_acc) begin
            unique case (bus_addr)
                ADDR_W'(OFS_POP):   bus_rdata = head_data;
                ADDR_W'(OFS_STAT):  bus_rdata = status_word;
                ADDR_W'(OFS_WMARK): bus_rdata = DATA_W'(wm_q);
                ADDR_W'(OFS_IEN_A): bus_rdata = DATA_W'(en_a_q);
                ADDR_W'(OFS_IEN_B): bus_rdata = DATA_W'(en_b_q);
                ADDR_W'(OFS_ISTAT): bus_rdata = DATA_W'(istat_q);
                default:            bus_rdata = '0;
            endcase
        end
    end

    p_empty_pop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state_q == FILL_EMPTY) |-> (bus_rdata == '0));

    p_uflow_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state_q == FILL_EMPTY) |=> istat_q[EV_UFLOW]);

endmodule

// File: tb/mbx_fifo_chan_test.sv
module mbx_fifo_chan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_a, irq_b;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mbx_fifo_chan uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_a     (irq_a),
        .irq_b     (irq_b)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'hB4, v); check("R1", "status", v, 32'h4);
        rd(8'hB8, v); check("R1", "watermark", v, 32'd32);
        rd(8'hDC, v); check("R1", "istat", v, 32'h0);
        rd(8'hD0, v); check("R1", "enable A", v, 32'h0);
        rd(8'hD4, v); check("R1", "enable B", v, 32'h0);
        check("R1", "irq lines", {30'd0, irq_a, irq_b}, 32'h0);
    endtask

    task automatic t_order();
        logic [31:0] v;
        wr(8'hD0, 32'hFFFF_FFFF);
        rd(8'hD0, v); check("R9", "enable A implemented bits", v, 32'h1FC);
        wr(8'hD0, 32'h8);
        wr(8'hD4, 32'h100);
        for (int i = 0; i < 3; i++) wr(8'hAC, 32'hA500_0000 + i);
        check("R9", "irq_b on not-empty", {31'd0, irq_b}, 32'h1);
        check("R9", "irq_a idle", {31'd0, irq_a}, 32'h0);
        for (int i = 0; i < 3; i++) begin
            rd(8'hB0, v); check("R2", "pop order", v, 32'hA500_0000 + i);
        end
        rd(8'hDC, v); check("R7", "empty and not-empty events", v, 32'h108);
        check("R9", "irq_a on empty", {31'd0, irq_a}, 32'h1);
        wr(8'hD8, 32'h1FF);
        rd(8'hDC, v); check("R7", "empty not re-raised while empty", v, 32'h0);
        check("R9", "irq lines after clear", {30'd0, irq_a, irq_b}, 32'h0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        for (int i = 0; i < 32; i++) wr(8'hAC, 32'h1000 + i);
        rd(8'hB4, v); check("R3", "status full+wm", v, 32'h3);
        wr(8'hAC, 32'hDEAD_BEEF);
        rd(8'hB4, v); check("R3", "status overflow", v, 32'h13);
        rd(8'hDC, v); check("R3", "istat after overflow", v, 32'h154);
        for (int i = 0; i < 32; i++) begin
            rd(8'hB0, v); check("R3", "drained word", v, 32'h1000 + i);
        end
        rd(8'hB4, v); check("R3", "overflow sticky after drain", v, 32'h14);
        rd(8'hDC, v); check("R6", "wm down and empty events", v, 32'h17C);
        wr(8'hD8, 32'h40);
        rd(8'hDC, v); check("R8", "only bit 6 cleared", v, 32'h13C);
        rd(8'hB4, v); check("R8", "overflow flag cleared", v, 32'h4);
    endtask

    task automatic t_under();
        logic [31:0] v;
        rd(8'hB0, v); check("R4", "empty pop value", v, 32'h0);
        rd(8'hB4, v); check("R4", "status underflow", v, 32'hC);
        rd(8'hDC, v); check("R4", "istat underflow bit", v & 32'h80, 32'h80);
        wr(8'hCC, 32'h1);
        rd(8'hB4, v); check("R10", "flush clears underflow", v, 32'h4);
    endtask

    task automatic t_wm();
        logic [31:0] v;
        wr(8'hD8, 32'h1FF);
        wr(8'hB8, 32'd4);
        rd(8'hB8, v); check("R5", "watermark readback", v, 32'd4);
        for (int i = 0; i < 3; i++) wr(8'hAC, 32'h77 + i);
        rd(8'hB4, v); check("R5", "below watermark", v, 32'h0);
        wr(8'hAC, 32'h7A);
        rd(8'hB4, v); check("R5", "at watermark", v, 32'h1);
        rd(8'hDC, v); check("R6", "upward crossing", v & 32'h30, 32'h10);
        rd(8'hB0, v); check("R2", "head word", v, 32'h77);
        rd(8'hDC, v); check("R6", "downward crossing", v & 32'h30, 32'h30);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        wr(8'hCC, 32'h0);
        rd(8'hB4, v); check("R10", "flush with bit0=0 ignored", v, 32'h0);
        rd(8'hB0, v); check("R10", "word kept after ignored flush", v, 32'h78);
        wr(8'hCC, 32'h1);
        rd(8'hB4, v); check("R10", "status after flush", v, 32'h4);
        rd(8'hB8, v); check("R10", "watermark kept", v, 32'd4);
        rd(8'hB0, v); check("R10", "nothing left after flush", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_under();
        t_wm();
        t_flush();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule